// File: doc/BRIEF.md
# Vector Tree Reduction Sequencer

This block adds up an arbitrarily long stream of integers. The stream arrives as chunks of VL elements over a valid/ready handshake. A bank of VL partial-sum registers starts at zero. Each accepted chunk is added into the bank element by element, so lane i only ever sees element i of each chunk. A chunk can carry fewer than VL live elements. In that case the unused upper elements are treated as zeros.

When the chunk flagged as last has been accepted, the block folds the bank. On each fold cycle the active length halves and the upper half of the live partials is added onto the lower half. After log2(VL) folds the complete sum sits in element 0. It is presented for a single cycle, the bank is cleared, and the block is ready for the next stream. All arithmetic is unsigned and wraps modulo 2^W.

The controller has three states:
- ST_ACCUM accepts chunks.
- ST_FOLD performs one halving step per cycle.
- ST_DONE presents the result.

It has three transitions:
- T_LAST (ST_ACCUM to ST_FOLD) fires when a chunk with the last flag is accepted.
- T_FOLDED (ST_FOLD to ST_DONE) fires on the fold step whose active length is 2.
- T_EMIT (ST_DONE to ST_ACCUM) fires unconditionally after one cycle.

Top module: `vred_seq`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and every partial sum is zero.
- R2: A chunk is accepted on a rising edge where in_valid and in_ready are both 1. Element i (bits i*W+W-1 down to i*W of in_data) is then added into partial sum i.
- R3: Only elements with index below in_len are added. An in_len of 0 adds nothing. An in_len of VL or more adds all VL elements.
- R4: Once a chunk with in_last=1 is accepted, in_ready stays 0 until the clock edge that ends the result cycle. in_ready is 1 again in the cycle after that.
- R5: Folding takes log2(VL) cycles. out_valid is 1 in the cycle that starts log2(VL) rising edges after the edge that accepted the last chunk, and 0 in the cycles before it.
- R6: out_valid is a single-cycle pulse.
- R7: While out_valid is 1, out_sum equals the sum of every element added since the previous result (or since reset), modulo 2^W.
- R8: The partial sums are zero again after a result is presented, so the next reduction does not depend on the previous one.
- R9: in_valid, in_data, in_len and in_last have no effect while in_ready is 0, and the partial sums hold while no chunk is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Chunk present on in_data |
| in_ready | output | 1 | Block accepts a chunk this cycle |
| in_data | input | VL*W | VL elements; element i at bits i*W+W-1 down to i*W |
| in_len | input | log2(VL)+1 | Number of live elements, counted from element 0 |
| in_last | input | 1 | This chunk ends the stream |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | W | Reduced sum, valid while out_valid is 1 |

## Verification
The in-RTL assertions watch the following on every cycle:
- that the active length halves exactly once per fold cycle;
- that the result cycle is entered only after the length-2 fold;
- the single-cycle width of the result pulse;
- the clearing of the bank after a result;
- that the bank holds while no chunk arrives and no fold or clear runs.

The numerical value of the sum can only be shown by the directed scenarios, which compare it against a model of the stream. The same holds for zero padding of short chunks, wraparound, the exact fold latency, and that input driven during folding is ignored.

// File: rtl/vred_pkg.sv
package vred_pkg;
    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_FOLD  = 2'd1,
        ST_DONE  = 2'd2
    } vred_state_e;
endpackage

// File: rtl/vred_ctrl.sv
module vred_ctrl
    import vred_pkg::*;
#(
    parameter int VL = 8,
    localparam int LW = $clog2(VL)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_last,
    output logic        in_ready,
    output logic        acc_en,
    output logic        fold_en,
    output logic        clr,
    output logic        out_valid,
    output logic [LW:0] fold_len
);
    localparam logic [LW:0] FULL_LEN = (LW+1)'(VL);

    vred_state_e state_q, state_d;
    logic [LW:0] len_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM: if (in_valid && in_last) state_d = ST_FOLD;   // T_LAST
            ST_FOLD:  if (len_q == (LW+1)'(2)) state_d = ST_DONE;   // T_FOLDED
            ST_DONE:  state_d = ST_ACCUM;                           // T_EMIT
            default:  state_d = ST_ACCUM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACCUM;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  len_q <= FULL_LEN;
        else if (state_q == ST_FOLD) len_q <= len_q >> 1;
        else                         len_q <= FULL_LEN;
    end

    always_comb begin
        in_ready  = 1'b0;
        acc_en    = 1'b0;
        fold_en   = 1'b0;
        clr       = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_ACCUM: begin
                in_ready = 1'b1;
                acc_en   = in_valid;
            end
            ST_FOLD:  fold_en = 1'b1;
            ST_DONE: begin
                out_valid = 1'b1;
                clr       = 1'b1;
            end
            default: ;
        endcase
    end

    assign fold_len = len_q;

    // R6
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R5
    fold_len_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en |-> ($countones(fold_len) == 1 && fold_len >= (LW+1)'(2)));

    // R5
    fold_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en |=> (out_valid || (fold_len == ($past(fold_len) >> 1))));

    // R5
    done_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(fold_en && fold_len == (LW+1)'(2)));
endmodule

// File: rtl/vred_lanes.sv
module vred_lanes #(
    parameter int VL = 8,
    parameter int W  = 16,
    localparam int LW = $clog2(VL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          fold_en,
    input  logic          clr,
    input  logic [VL*W-1:0] in_data,
    input  logic [LW:0]   in_len,
    input  logic [LW:0]   fold_len,
    output logic [W-1:0]  sum0
);
    logic [W-1:0]    part_q [VL];
    logic [VL*W-1:0] part_flat;
    logic [LW:0]     half;

    assign half = fold_len >> 1;

    for (genvar i = 0; i < VL; i++) begin : g_lane
        logic [LW-1:0] src_idx;
        logic [W-1:0]  in_el;
        logic          live;

        assign src_idx = LW'(i) + half[LW-1:0];
        assign in_el   = in_data[i*W +: W];
        assign live    = (LW+1)'(i) < in_len;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                part_q[i] <= '0;
            else if (clr)
                part_q[i] <= '0;
            else if (acc_en)
                part_q[i] <= part_q[i] + (live ? in_el : '0);
            else if (fold_en && ((LW+1)'(i) < half))
                part_q[i] <= part_q[i] + part_q[src_idx];
        end

        assign part_flat[i*W +: W] = part_q[i];
    end

    assign sum0 = part_q[0];

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (part_flat == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en || fold_en || clr) |=> $stable(part_flat));
endmodule

// File: rtl/vred_seq.sv
module vred_seq #(
    parameter int VL = 8,
    parameter int W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [VL*W-1:0]       in_data,
    input  logic [$clog2(VL):0]   in_len,
    input  logic                  in_last,
    output logic                  out_valid,
    output logic [W-1:0]          out_sum
);
    localparam int LW = $clog2(VL);

    logic          acc_en;
    logic          fold_en;
    logic          clr;
    logic [LW:0]   fold_len;

    vred_ctrl #(.VL(VL)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .acc_en    (acc_en),
        .fold_en   (fold_en),
        .clr       (clr),
        .out_valid (out_valid),
        .fold_len  (fold_len)
    );

    vred_lanes #(.VL(VL), .W(W)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .fold_en  (fold_en),
        .clr      (clr),
        .in_data  (in_data),
        .in_len   (in_len),
        .fold_len (fold_len),
        .sum0     (out_sum)
    );
endmodule

// File: tb/vred_seq_bench.sv
module vred_seq_bench;
    localparam int VL  = 8;
    localparam int W   = 16;
    localparam int LW  = $clog2(VL);
    localparam int LOG = $clog2(VL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [VL*W-1:0] in_data = '0;
    logic [LW:0]     in_len = '0;
    logic            in_last = 1'b0;
    logic            out_valid;
    logic [W-1:0]    out_sum;

    int n_checks = 0;
    int n_fails  = 0;
    logic [W-1:0] exp_sum;

    always #5 clk = ~clk;

    vred_seq #(.VL(VL), .W(W)) u_vred_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_len    (in_len),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [VL*W-1:0] mk(input int base, input int step);
        logic [VL*W-1:0] v;
        for (int i = 0; i < VL; i++) v[i*W +: W] = W'(base + i*step);
        return v;
    endfunction

    // drive a chunk and update the model (R2, R3)
    task automatic send(input logic [VL*W-1:0] d, input int len, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_len   = (LW+1)'(len);
        in_last  = last;
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < VL; i++)
            if (i < len) exp_sum = exp_sum + d[i*W +: W];
        @(posedge clk);
    endtask

    // observe fold, result pulse and ready (R4, R5, R6, R7, R9)
    task automatic collect(input string name, input logic junk);
        for (int k = 1; k <= LOG + 2; k++) begin
            @(negedge clk);
            if (k <= LOG + 1 && junk) begin
                in_valid = 1'b1;
                in_data  = mk(16'h7777, 16'h0123);
                in_len   = (LW+1)'(VL);
                in_last  = 1'b1;
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            if (k <= LOG) begin
                check(out_valid == 1'b0, {"R5 early valid ", name}, out_valid, 0);
                check(in_ready == 1'b0, {"R4 ready in fold ", name}, in_ready, 0);
            end else if (k == LOG + 1) begin
                check(out_valid == 1'b1, {"R5 result cycle ", name}, out_valid, 1);
                check(out_sum == exp_sum, {"R7 sum ", name}, out_sum, exp_sum);
                check(in_ready == 1'b0, {"R4 ready in result ", name}, in_ready, 0);
            end else begin
                check(out_valid == 1'b0, {"R6 pulse width ", name}, out_valid, 0);
                check(in_ready == 1'b1, {"R4 ready back ", name}, in_ready, 1);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready at reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 valid at reset", out_valid, 0);
    endtask

    task automatic t_basic();
        exp_sum = '0;  // R1: bank starts at zero
        send(mk(1, 1), VL, 1'b0);
        send(mk(100, 3), VL, 1'b0);
        send(mk(7, 11), VL, 1'b1);
        collect("basic R2", 1'b0);
    endtask

    task automatic t_single();
        exp_sum = '0;  // R8: previous result must not leak
        send(mk(5, 2), VL, 1'b1);
        collect("single R8", 1'b0);
    endtask

    task automatic t_short();
        exp_sum = '0;  // R3 padding cases
        send(mk(16'h1000, 16'h0111), 3, 1'b0);
        send(mk(9, 9), 0, 1'b0);
        send(mk(2, 1), VL + 3, 1'b1);
        collect("short R3", 1'b0);
    endtask

    task automatic t_wrap();
        exp_sum = '0;  // R7 modulo 2^W
        send(mk(16'hFFF0, 1), VL, 1'b0);
        send(mk(16'hFFFF, 0), VL, 1'b1);
        collect("wrap R7", 1'b0);
    endtask

    task automatic t_ignore();
        exp_sum = '0;  // R9: idle data and busy-time data ignored
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = mk(16'h4444, 5);
        in_len   = (LW+1)'(VL);
        in_last  = 1'b1;
        repeat (3) @(negedge clk);
        send(mk(3, 4), VL, 1'b1);
        collect("ignore R9", 1'b1);
        exp_sum = '0;
        send(mk(1, 0), VL, 1'b1);
        collect("after ignore R9", 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_single();
        t_short();
        t_wrap();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule